// File: doc/BRIEF.md
# Dual-Source Outbound Character Arbiter

This block feeds a line encoder with one 7-bit character per word period. Two sources offer data: a primary source carrying bulk tracking words and a secondary source carrying slow-control words. Each source raises an availability flag while it holds a word at its output. The arbiter takes that word by pulsing the source's read enable for one clock. A 2-bit mode input selects which sources may be served: primary only, secondary only, priority (primary first, secondary only when the primary is empty), or none.

Every burst from a source opens with a header command character that identifies that source. Header words carry no data. When nothing can be sent, the arbiter emits an idle command character. A control flag travels with each character so that the encoder can map headers and idle words onto command codes that never decode as data. All decisions are made once per word period, at its last clock. The chosen word is registered and held for a full period, and a one-clock strobe marks its arrival. Reset is synchronous and active-low.

Top module: `txarb_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to its idle state. After that edge `enc_char_o` is the idle code 7'h7C, `enc_ctrl_o` is 1 and `enc_stb_o` is 0, and both read enables stay low for as long as `rst_n` is low.
- R2: After reset release, a decision is made every WORD_CYCLES clocks (default 4), at the WORD_CYCLES-th clock edge counted from release. `enc_stb_o` is high for exactly the one cycle that follows each such edge.
- R3: Mode encoding: 2'b00 serves only the primary source, 2'b01 serves only the secondary source and 2'b10 is priority mode. 2'b11 serves neither source, so only idle words are sent and no read enable is raised.
- R4: In priority mode, the primary source is chosen whenever it reports data. This holds even when a secondary burst is in progress: the primary header is sent at the very next word boundary.
- R5: A secondary burst starts only when the secondary source reports data. If the secondary is empty, an empty primary leads to an idle word, not to a secondary header.
- R6: The first word of a burst is a header with `enc_ctrl_o`=1: 7'h1E for the primary source and 7'h63 for the secondary source. No read enable is raised for a header word.
- R7: Each later word of a burst is the source's current data with `enc_ctrl_o`=0. It is fetched by a read enable that is high for exactly the decision clock of that word. The read enable is never raised for a source that does not report data, and never for both sources at once.
- R8: A word period with no eligible data carries the idle code 7'h7C with `enc_ctrl_o`=1. A burst that runs dry ends there, and any later data from that source is preceded by a fresh header.
- R9: The mode input is sampled only on the decision clock. Mode changes between decision clocks have no effect on the words sent or on the read enables.
- R10: Between strobes, `enc_char_o` and `enc_ctrl_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Source selection mode |
| pri_avail_i | input | 1 | Primary source holds a word |
| pri_data_i | input | 7 | Primary source word |
| pri_rd_o | output | 1 | Primary read enable, one clock per word taken |
| sec_avail_i | input | 1 | Secondary source holds a word |
| sec_data_i | input | 7 | Secondary source word |
| sec_rd_o | output | 1 | Secondary read enable, one clock per word taken |
| enc_char_o | output | 7 | Character to the encoder |
| enc_ctrl_o | output | 1 | High for header and idle characters |
| enc_stb_o | output | 1 | One-clock marker of a new character |

## Verification
The hardest situations to reach are those that depend on where the word boundary falls. One is a secondary burst cut short by a primary word that shows up mid-period. The other is a mode change that is made and undone between two decision clocks. The bench keeps its own phase counter from reset release. It uses that counter to place a primary arrival inside a running secondary burst, and to toggle the mode only on non-decision clocks while both sources are full. Random mode changes and random source fills at many densities are then added on top of these directed cases.

// File: rtl/txarb_pkg.sv
package txarb_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_PRI  = 2'd1,
      SRC_SEC  = 2'd2
   } src_e;

   typedef enum logic [1:0] {
      MODE_PRI_ONLY = 2'b00,
      MODE_SEC_ONLY = 2'b01,
      MODE_PRIORITY = 2'b10,
      MODE_OFF      = 2'b11
   } mode_e;

   function automatic logic pri_allowed(input mode_e m);
      return (m == MODE_PRI_ONLY) || (m == MODE_PRIORITY);
   endfunction

   function automatic logic sec_allowed(input mode_e m);
      return (m == MODE_SEC_ONLY) || (m == MODE_PRIORITY);
   endfunction

endpackage

// File: rtl/txarb_word_timer.sv
module txarb_word_timer #(
   parameter int unsigned WORD_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (WORD_CYCLES > 1) ? $clog2(WORD_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(WORD_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_q == LAST)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CW'(1);
   end

   assign tick = (cnt_q == LAST);

   generate
      if (WORD_CYCLES < 1) begin : g_bad_period
         $error("WORD_CYCLES must be at least 1");
      end
      if (WORD_CYCLES > 1) begin : g_spacing
         // R2
         tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/txarb_src_pick.sv
module txarb_src_pick
   import txarb_pkg::*;
#(
   parameter bit PREEMPT = 1'b1
) (
   input  mode_e mode,
   input  logic  pri_avail,
   input  logic  sec_avail,
   input  src_e  cur,
   output src_e  pick
);
   localparam bit SEC_FINISHES = (PREEMPT == 1'b0);

   logic cand_p, cand_s, hold_sec;

   assign cand_p   = pri_allowed(mode) && pri_avail;
   assign cand_s   = sec_allowed(mode) && sec_avail;
   assign hold_sec = SEC_FINISHES && (cur == SRC_SEC) && cand_s;

   always_comb begin
      if (hold_sec)
         pick = SRC_SEC;
      else if (cand_p)
         pick = SRC_PRI;
      else if (cand_s)
         pick = SRC_SEC;
      else
         pick = SRC_NONE;
   end

endmodule

// File: rtl/txarb_word_mux.sv
module txarb_word_mux
   import txarb_pkg::*;
#(
   parameter int unsigned     CHAR_W   = 7,
   parameter logic [CHAR_W-1:0] IDLE_CODE = 7'h7C,
   parameter logic [CHAR_W-1:0] PRI_HDR  = 7'h1E,
   parameter logic [CHAR_W-1:0] SEC_HDR  = 7'h63
) (
   input  src_e              pick,
   input  src_e              cur,
   input  logic [CHAR_W-1:0] pri_data,
   input  logic [CHAR_W-1:0] sec_data,
   output logic [CHAR_W-1:0] char_o,
   output logic              ctrl_o,
   output logic              rd_p,
   output logic              rd_s
);
   logic opening;

   assign opening = (pick != SRC_NONE) && (pick != cur);

   always_comb begin
      char_o = IDLE_CODE;
      ctrl_o = 1'b1;
      rd_p   = 1'b0;
      rd_s   = 1'b0;
      unique case (pick)
         SRC_PRI: begin
            if (opening) begin
               char_o = PRI_HDR;
            end else begin
               char_o = pri_data;
               ctrl_o = 1'b0;
               rd_p   = 1'b1;
            end
         end
         SRC_SEC: begin
            if (opening) begin
               char_o = SEC_HDR;
            end else begin
               char_o = sec_data;
               ctrl_o = 1'b0;
               rd_s   = 1'b1;
            end
         end
         default: begin
            char_o = IDLE_CODE;
         end
      endcase
   end

endmodule

// File: rtl/txarb_top.sv
module txarb_top
   import txarb_pkg::*;
#(
   parameter int unsigned       CHAR_W      = 7,
   parameter int unsigned       WORD_CYCLES = 4,
   parameter bit                PREEMPT     = 1'b1,
   parameter logic [CHAR_W-1:0] IDLE_CODE   = 7'h7C,
   parameter logic [CHAR_W-1:0] PRI_HDR     = 7'h1E,
   parameter logic [CHAR_W-1:0] SEC_HDR     = 7'h63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic              pri_avail_i,
   input  logic [CHAR_W-1:0] pri_data_i,
   output logic              pri_rd_o,
   input  logic              sec_avail_i,
   input  logic [CHAR_W-1:0] sec_data_i,
   output logic              sec_rd_o,
   output logic [CHAR_W-1:0] enc_char_o,
   output logic              enc_ctrl_o,
   output logic              enc_stb_o
);

   generate
      if (CHAR_W < 2) begin : g_bad_width
         $error("CHAR_W must be at least 2");
      end
      if ((IDLE_CODE == PRI_HDR) || (IDLE_CODE == SEC_HDR) || (PRI_HDR == SEC_HDR)) begin : g_bad_codes
         $error("idle and header codes must be distinct");
      end
   endgenerate

   src_e              st_q, pick;
   logic              tick;
   logic [CHAR_W-1:0] nxt_char;
   logic              nxt_ctrl, want_p, want_s;

   txarb_word_timer #(.WORD_CYCLES(WORD_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   txarb_src_pick #(.PREEMPT(PREEMPT)) u_pick (
      .mode      (mode_e'(mode_i)),
      .pri_avail (pri_avail_i),
      .sec_avail (sec_avail_i),
      .cur       (st_q),
      .pick      (pick)
   );

   txarb_word_mux #(
      .CHAR_W    (CHAR_W),
      .IDLE_CODE (IDLE_CODE),
      .PRI_HDR   (PRI_HDR),
      .SEC_HDR   (SEC_HDR)
   ) u_mux (
      .pick     (pick),
      .cur      (st_q),
      .pri_data (pri_data_i),
      .sec_data (sec_data_i),
      .char_o   (nxt_char),
      .ctrl_o   (nxt_ctrl),
      .rd_p     (want_p),
      .rd_s     (want_s)
   );

   assign pri_rd_o = rst_n && tick && want_p;
   assign sec_rd_o = rst_n && tick && want_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= SRC_NONE;
         enc_char_o <= IDLE_CODE;
         enc_ctrl_o <= 1'b1;
         enc_stb_o  <= 1'b0;
      end else begin
         enc_stb_o <= tick;
         if (tick) begin
            st_q       <= pick;
            enc_char_o <= nxt_char;
            enc_ctrl_o <= nxt_ctrl;
         end
      end
   end

   // R7
   rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pri_rd_o, sec_rd_o}));

   // R7
   pri_rd_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pri_rd_o |-> pri_avail_i);

   // R7
   sec_rd_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_rd_o |-> sec_avail_i);

   // R2
   rd_then_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_rd_o || sec_rd_o) |=> enc_stb_o);

   // R10
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enc_stb_o |-> ($stable(enc_char_o) && $stable(enc_ctrl_o)));

   // R6
   data_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_stb_o && !enc_ctrl_o) |-> $past(pri_rd_o || sec_rd_o));

   // R3
   mode_blocks_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b01 || mode_i == 2'b11) |-> !pri_rd_o);

   // R3
   mode_blocks_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00 || mode_i == 2'b11) |-> !sec_rd_o);

endmodule

// File: tb/tb_txarb_top.sv
`timescale 1ns/1ps
module tb_txarb_top;
   localparam int W = 4;
   localparam logic [6:0] IDLE = 7'h7C, PHDR = 7'h1E, SHDR = 7'h63;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b10;
   logic       pri_avail = 1'b0, sec_avail = 1'b0;
   logic [6:0] pri_data = '0, sec_data = '0;
   logic       pri_rd, sec_rd, enc_ctrl, enc_stb;
   logic [6:0] enc_char;

   always #2 clk = ~clk;

   txarb_top dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode),
      .pri_avail_i(pri_avail), .pri_data_i(pri_data), .pri_rd_o(pri_rd),
      .sec_avail_i(sec_avail), .sec_data_i(sec_data), .sec_rd_o(sec_rd),
      .enc_char_o(enc_char), .enc_ctrl_o(enc_ctrl), .enc_stb_o(enc_stb)
   );

   int nchk = 0, nfail = 0;
   string phase = "init";
   logic [6:0] qp[$];
   logic [6:0] qs[$];

   // bench model state
   int         ph = 0;
   int         st = 0;          // 0 none, 1 primary, 2 secondary
   logic [6:0] exp_char = IDLE;
   logic       exp_ctrl = 1'b1;
   logic       exp_stb = 1'b0;
   string      exp_tag = "R1";

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s [%s] got=%0h exp=%0h", req, phase, got, exp);
      end
   endtask

   // requirement-level choice (R3, R4, R5)
   function automatic int choose(input logic [1:0] m, input bit pa, input bit sa);
      bit ap, as;
      ap = (m == 2'b00) || (m == 2'b10);
      as = (m == 2'b01) || (m == 2'b10);
      if (ap && pa) return 1;
      if (as && sa) return 2;
      return 0;
   endfunction

   task automatic step(input bit rv, input logic [1:0] m, input bit pp, input bit ps);
      int  pk;
      bit  tk, ep, es;
      @(negedge clk);
      chk({exp_tag, "/R10 char"}, enc_char, exp_char);
      chk({exp_tag, "/R10 ctrl"}, enc_ctrl, exp_ctrl);
      chk("R2 strobe", enc_stb, exp_stb);
      rst_n = rv;
      mode  = m;
      if (pp && qp.size() < 16) qp.push_back(7'($urandom));
      if (ps && qs.size() < 16) qs.push_back(7'($urandom));
      pri_avail = (qp.size() != 0);
      sec_avail = (qs.size() != 0);
      pri_data  = pri_avail ? qp[0] : 7'h00;
      sec_data  = sec_avail ? qs[0] : 7'h00;
      #1;
      if (!rv) begin
         // R1
         chk("R1 pri_rd", pri_rd, 0);
         chk("R1 sec_rd", sec_rd, 0);
         ph = 0; st = 0; exp_char = IDLE; exp_ctrl = 1'b1; exp_stb = 1'b0; exp_tag = "R1";
      end else begin
         tk = (ph == W-1);
         pk = choose(m, pri_avail, sec_avail);
         ep = tk && pk == 1 && st == 1;
         es = tk && pk == 2 && st == 2;
         // R7 / R9: reads only at decision clock with sampled mode
         chk("R7/R9 pri_rd", pri_rd, ep);
         chk("R7/R9 sec_rd", sec_rd, es);
         if (tk) begin
            if (pk == 0) begin
               exp_char = IDLE; exp_ctrl = 1'b1;
               exp_tag = (m == 2'b11) ? "R3" : "R8";
            end else if (pk != st) begin
               exp_char = (pk == 1) ? PHDR : SHDR; exp_ctrl = 1'b1; exp_tag = "R6";
            end else if (pk == 1) begin
               exp_char = qp.pop_front(); exp_ctrl = 1'b0; exp_tag = "R7";
            end else begin
               exp_char = qs.pop_front(); exp_ctrl = 1'b0; exp_tag = "R7";
            end
            st = pk;
            exp_stb = 1'b1;
            ph = 0;
         end else begin
            exp_stb = 1'b0;
            ph = ph + 1;
         end
      end
   endtask

   task automatic run(input int n, input bit rv, input logic [1:0] m, input int pct_p, input int pct_s);
      for (int i = 0; i < n; i++)
         step(rv, m, ($urandom % 100) < pct_p, ($urandom % 100) < pct_s);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog [%s] got=hung exp=done", phase);
      summary();
   end

   initial begin
      int seed;
      seed = $urandom(32'h5EED);

      phase = "R1 reset";
      run(5, 1'b0, 2'b10, 0, 0);

      phase = "R8 idle priority empty";
      run(3*W, 1'b1, 2'b10, 0, 0);

      phase = "R3 mode off";
      for (int i = 0; i < 3; i++) begin qp.push_back(7'(i+5)); qs.push_back(7'(i+9)); end
      run(4*W, 1'b1, 2'b11, 0, 0);

      phase = "R3 primary only";
      run(6*W, 1'b1, 2'b00, 0, 0);

      phase = "R5 secondary empty after primary drain";
      qs.delete();
      qp.push_back(7'h11); qp.push_back(7'h22);
      run(6*W, 1'b1, 2'b10, 0, 0);

      phase = "R3 secondary only";
      for (int i = 0; i < 3; i++) qs.push_back(7'(i+40));
      run(6*W, 1'b1, 2'b01, 0, 0);

      phase = "R4 preempt secondary burst";
      qp.delete(); qs.delete();
      for (int i = 0; i < 8; i++) qs.push_back(7'(i+60));
      run(3*W, 1'b1, 2'b10, 0, 0);
      while (ph != 1) run(1, 1'b1, 2'b10, 0, 0);
      qp.push_back(7'h55); qp.push_back(7'h56);
      run(5*W, 1'b1, 2'b10, 0, 0);

      phase = "R9 mode glitch between boundaries";
      for (int i = 0; i < 6; i++) begin qp.push_back(7'(i)); qs.push_back(7'(i+90)); end
      for (int i = 0; i < 5*W; i++)
         step(1'b1, (ph == W-1) ? 2'b10 : 2'b01, 1'b0, 1'b0);

      phase = "R1 mid-run reset";
      run(2, 1'b0, 2'b10, 0, 0);
      run(3*W, 1'b1, 2'b10, 30, 30);

      phase = "random";
      begin
         logic [1:0] m;
         m = 2'b10;
         for (int i = 0; i < 4000; i++) begin
            if (($urandom % 40) == 0) m = 2'($urandom);
            step(1'b1, m, ($urandom % 100) < 20, ($urandom % 100) < 25);
         end
      end

      summary();
   end

endmodule